// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block holds a small set of recently used page-to-frame translations. Each entry carries an address-space tag, so translations that belong to different processes can sit side by side. A context switch then only changes the identifier that comes with each lookup, and the table does not have to be emptied. A lookup offers a page number and the current address-space identifier. Every entry compares itself against that pair in the same cycle. One cycle after the lookup is accepted, the block returns either a hit with the stored frame number and its access rights, or a miss.

The hit path is what saves time. Without this block, every access needs two memory cycles: one to read the page table and one for the data. With a hit, the cost is one lookup plus one memory cycle. After a miss, a separate walker reads the page table. It then writes the result back through the refill channel. Refill reuses a slot that already holds the same page and identifier. Otherwise it takes the lowest free slot, or evicts a victim chosen in rotation once every slot is in use.

Two flush controls drop entries: one empties the whole table, the other drops only the entries of a single address space. Two free-running counters record hits and misses, so the hit ratio can be measured.

Lookup requests and responses use valid/ready handshakes. A response is held unchanged while its ready input is low. While a response is held, no new lookup is accepted, so lookups never overtake each other. The refill channel is also valid/ready, and its ready output drops only while a flush is asserted.

Top module: `tlb_asid_cache`

## Requirements
- R1: After reset, rsp_valid is 0, lk_ready and rf_ready are 1, both counters read 0, and no lookup hits.
- R2: A lookup is accepted on a clock edge where lk_valid and lk_ready are both 1. From the next cycle, rsp_valid is 1. rsp_hit is 1 when a valid entry holds the same page and identifier, and in that case rsp_frame and rsp_prot come from that entry (rights bit 0 = read, bit 1 = write, bit 2 = execute). On a miss, rsp_frame and rsp_prot are 0.
- R3: An entry hits only when its stored identifier equals lk_asid. The same page under a different identifier misses or returns that identifier's own frame.
- R4: A lookup accepted in the same cycle as a refill or a flush sees the table as it was before that update.
- R5: While any entry is invalid, an accepted refill of a new page/identifier pair takes the lowest-numbered invalid entry and evicts no valid entry.
- R6: When all entries are valid, an accepted refill of a new pair evicts the entry at a rotating pointer. The pointer starts at entry 0 after reset, advances by one after each such eviction, and wraps from the last entry to 0.
- R7: A refill whose page and identifier match a valid entry overwrites that entry's frame and rights, and does not move the rotating pointer.
- R8: While flush_asid_en is 1, every entry whose identifier equals flush_asid becomes invalid at the next edge. Other entries are kept.
- R9: While flush_all is 1, every entry becomes invalid at the next edge.
- R10: While either flush input is 1, rf_ready is 0, and a refill offered in that cycle leaves the table unchanged.
- R11: lk_ready equals (not rsp_valid) or rsp_ready. While rsp_valid is 1 and rsp_ready is 0, the response stays valid and unchanged.
- R12: Each accepted lookup adds exactly one to hit_count on a hit or to miss_count on a miss. No other event changes either counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request can be accepted |
| lk_page | input | 20 | Page number to translate |
| lk_asid | input | 8 | Identifier of the current address space |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Response is a hit |
| rsp_frame | output | 20 | Frame number on a hit, 0 on a miss |
| rsp_prot | output | 3 | Access rights on a hit (bit 0 read, bit 1 write, bit 2 execute) |
| rf_valid | input | 1 | Refill request valid |
| rf_ready | output | 1 | Refill can be accepted (low during a flush) |
| rf_page | input | 20 | Page number to install |
| rf_asid | input | 8 | Identifier of the translation |
| rf_frame | input | 20 | Frame number to install |
| rf_prot | input | 3 | Access rights to install |
| flush_all | input | 1 | Invalidate every entry |
| flush_asid_en | input | 1 | Invalidate entries of one address space |
| flush_asid | input | 8 | Address space to invalidate |
| hit_count | output | 32 | Number of accepted lookups that hit |
| miss_count | output | 32 | Number of accepted lookups that missed |

## Verification
The bench fills the whole table and then keeps refilling. It checks that victims are taken in rotation, and that a refill of a pair already present leaves the pointer where it was. A design that advanced the pointer on that rewrite would evict the wrong neighbour on the next refill. After a partial flush, the bench checks that new translations land in the freed slots. A design that kept evicting in rotation would lose live translations from another address space.

The bench offers a refill or a flush in the same cycle as a lookup of the same page. A design that forwards the update would turn the expected miss into a hit, or the expected hit into a miss. It offers refills while a flush is asserted; a design that accepted them would show a translation that should not exist. Finally, it holds the response channel stalled. A design that let a new lookup overwrite the held response, or that counted a lookup that was never accepted, would show up in the response stream and in the counters.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

  // width of the access-rights field: bit 0 read, bit 1 write, bit 2 execute
  localparam int unsigned PROT_W = 3;

  // where the refill slot came from
  typedef enum logic [1:0] {
    SLOT_REUSE = 2'd0,   // same page and identifier already present
    SLOT_FREE  = 2'd1,   // lowest invalid entry
    SLOT_ROTATE = 2'd2   // rotating eviction pointer
  } slot_src_e;

endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PAGE_W  = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned FRAME_W = 20,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned PROT_W = tlb_pkg::PROT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [ASID_W-1:0]  wr_asid,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [PROT_W-1:0]  wr_prot,
  input  logic               kill_all,
  input  logic               kill_asid_en,
  input  logic [ASID_W-1:0]  kill_asid,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ENTRIES-1:0] wr_match_vec,
  output logic [ENTRIES-1:0] valid_vec,
  output logic [FRAME_W-1:0] rd_frame,
  output logic [PROT_W-1:0]  rd_prot
);

  logic [FRAME_W-1:0] frame_arr [ENTRIES];
  logic [PROT_W-1:0]  prot_arr  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic               v_q;
    logic [PAGE_W-1:0]  page_q;
    logic [ASID_W-1:0]  asid_q;
    logic [FRAME_W-1:0] frame_q;
    logic [PROT_W-1:0]  prot_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q     <= 1'b0;
        page_q  <= '0;
        asid_q  <= '0;
        frame_q <= '0;
        prot_q  <= '0;
      end else if (kill_all) begin
        v_q <= 1'b0;
      end else if (kill_asid_en && (asid_q == kill_asid)) begin
        v_q <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        v_q     <= 1'b1;
        page_q  <= wr_page;
        asid_q  <= wr_asid;
        frame_q <= wr_frame;
        prot_q  <= wr_prot;
      end
    end

    assign valid_vec[g]    = v_q;
    assign hit_vec[g]      = v_q && (page_q == lk_page) && (asid_q == lk_asid);
    assign wr_match_vec[g] = v_q && (page_q == wr_page) && (asid_q == wr_asid);
    assign frame_arr[g]    = frame_q;
    assign prot_arr[g]     = prot_q;
  end

  // at most one entry hits, so an AND-OR merge selects the payload
  always_comb begin
    rd_frame = '0;
    rd_prot  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) begin
        rd_frame = rd_frame | frame_arr[i];
        rd_prot  = rd_prot  | prot_arr[i];
      end
    end
  end

endmodule

// File: rtl/tlb_victim_sel.sv
`timescale 1ns/1ps
module tlb_victim_sel #(
  parameter int unsigned ENTRIES = 16,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   slot_idx
);
  import tlb_pkg::*;

  logic [IDX_W-1:0] rot_q;
  logic [IDX_W-1:0] free_idx;
  logic [IDX_W-1:0] match_idx;
  logic             any_free;
  logic             any_match;
  slot_src_e        src;

  // lowest-numbered invalid and matching entries
  always_comb begin
    free_idx  = '0;
    match_idx = '0;
    any_free  = 1'b0;
    any_match = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IDX_W'(i);
        any_free = 1'b1;
      end
      if (match_vec[i]) begin
        match_idx = IDX_W'(i);
        any_match = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_match)     src = SLOT_REUSE;
    else if (any_free) src = SLOT_FREE;
    else               src = SLOT_ROTATE;
  end

  always_comb begin
    case (src)
      SLOT_REUSE: slot_idx = match_idx;
      SLOT_FREE:  slot_idx = free_idx;
      default:    slot_idx = rot_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q <= '0;
    end else if (alloc && (src == SLOT_ROTATE)) begin
      if (rot_q == IDX_W'(ENTRIES - 1)) rot_q <= '0;
      else                              rot_q <= rot_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_hit_stats.sv
`timescale 1ns/1ps
module tlb_hit_stats #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_hit,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_count  <= '0;
      miss_count <= '0;
    end else if (ev_valid) begin
      if (ev_hit) hit_count  <= hit_count + 1'b1;
      else        miss_count <= miss_count + 1'b1;
    end
  end

endmodule

// File: rtl/tlb_asid_cache.sv
`timescale 1ns/1ps
module tlb_asid_cache #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned PAGE_W  = 20,
  parameter int unsigned ASID_W  = 8,
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned CNT_W   = 32,
  localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int unsigned PROT_W = tlb_pkg::PROT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [PAGE_W-1:0]  lk_page,
  input  logic [ASID_W-1:0]  lk_asid,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_hit,
  output logic [FRAME_W-1:0] rsp_frame,
  output logic [PROT_W-1:0]  rsp_prot,
  input  logic               rf_valid,
  output logic               rf_ready,
  input  logic [PAGE_W-1:0]  rf_page,
  input  logic [ASID_W-1:0]  rf_asid,
  input  logic [FRAME_W-1:0] rf_frame,
  input  logic [PROT_W-1:0]  rf_prot,
  input  logic               flush_all,
  input  logic               flush_asid_en,
  input  logic [ASID_W-1:0]  flush_asid,
  output logic [CNT_W-1:0]   hit_count,
  output logic [CNT_W-1:0]   miss_count
);

  logic               lk_fire;
  logic               rf_fire;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] rf_match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [FRAME_W-1:0] rd_frame;
  logic [PROT_W-1:0]  rd_prot;
  logic [IDX_W-1:0]   slot_idx;
  logic               any_hit;

  logic               rsp_valid_q;
  logic               rsp_hit_q;
  logic [FRAME_W-1:0] rsp_frame_q;
  logic [PROT_W-1:0]  rsp_prot_q;

  // handshakes
  assign lk_ready = !rsp_valid_q || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign rf_ready = !(flush_all || flush_asid_en);
  assign rf_fire  = rf_valid && rf_ready;
  assign any_hit  = |hit_vec;

  tlb_entry_array #(
    .ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .ASID_W(ASID_W), .FRAME_W(FRAME_W)
  ) u_array (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_page      (lk_page),
    .lk_asid      (lk_asid),
    .wr_page      (rf_page),
    .wr_asid      (rf_asid),
    .wr_en        (rf_fire),
    .wr_idx       (slot_idx),
    .wr_frame     (rf_frame),
    .wr_prot      (rf_prot),
    .kill_all     (flush_all),
    .kill_asid_en (flush_asid_en),
    .kill_asid    (flush_asid),
    .hit_vec      (hit_vec),
    .wr_match_vec (rf_match_vec),
    .valid_vec    (valid_vec),
    .rd_frame     (rd_frame),
    .rd_prot      (rd_prot)
  );

  tlb_victim_sel #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .match_vec (rf_match_vec),
    .alloc     (rf_fire),
    .slot_idx  (slot_idx)
  );

  tlb_hit_stats #(.CNT_W(CNT_W)) u_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_valid   (lk_fire),
    .ev_hit     (any_hit),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  // response stage: loads on an accepted lookup, holds while stalled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_frame_q <= '0;
      rsp_prot_q  <= '0;
    end else if (lk_fire) begin
      rsp_valid_q <= 1'b1;
      rsp_hit_q   <= any_hit;
      rsp_frame_q <= rd_frame;
      rsp_prot_q  <= rd_prot;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_hit   = rsp_hit_q;
  assign rsp_frame = rsp_frame_q;
  assign rsp_prot  = rsp_prot_q;

endmodule

// File: rtl/tlb_asid_chk.sv
`timescale 1ns/1ps
module tlb_asid_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned CNT_W   = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_hit,
  input logic [FRAME_W-1:0] rsp_frame,
  input logic [2:0]         rsp_prot,
  input logic               rf_ready,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic [CNT_W-1:0]   hit_count,
  input logic [CNT_W-1:0]   miss_count,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] hit_vec
);

  logic [CNT_W-1:0] cnt_sum;
  assign cnt_sum = hit_count + miss_count;

  // R7: refill reuse keeps at most one entry per page and identifier
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R2: a miss carries no frame and no rights
  assert_miss_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_frame == '0 && rsp_prot == '0));

  // R9: global flush empties the table at the next edge
  assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> (valid_vec == '0));

  // R10: no refill accepted while flushing
  assert_flush_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all || flush_asid_en) |-> !rf_ready);

  // R11: stalled response is held
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=>
      (rsp_valid && $stable(rsp_hit) && $stable(rsp_frame) && $stable(rsp_prot)));

  // R11: no new lookup taken while a response is stalled
  assert_stall_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !lk_ready);

  // R12: one count per accepted lookup
  assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> (cnt_sum == $past(cnt_sum) + 1'b1));

  // R12: counters still without an accepted lookup
  assert_count_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> ($stable(hit_count) && $stable(miss_count)));

endmodule

bind tlb_asid_cache tlb_asid_chk #(
  .ENTRIES(ENTRIES), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .lk_valid      (lk_valid),
  .lk_ready      (lk_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_hit       (rsp_hit),
  .rsp_frame     (rsp_frame),
  .rsp_prot      (rsp_prot),
  .rf_ready      (rf_ready),
  .flush_all     (flush_all),
  .flush_asid_en (flush_asid_en),
  .hit_count     (hit_count),
  .miss_count    (miss_count),
  .valid_vec     (valid_vec),
  .hit_vec       (hit_vec)
);

// File: tb/tlb_asid_cache_tb_top.sv
`timescale 1ns/1ps
module tlb_asid_cache_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [19:0] lk_page = '0;
  logic [7:0]  lk_asid = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_hit;
  logic [19:0] rsp_frame;
  logic [2:0]  rsp_prot;
  logic        rf_valid = 1'b0;
  logic        rf_ready;
  logic [19:0] rf_page = '0;
  logic [7:0]  rf_asid = '0;
  logic [19:0] rf_frame = '0;
  logic [2:0]  rf_prot = '0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [7:0]  flush_asid = '0;
  logic [31:0] hit_count;
  logic [31:0] miss_count;

  always #2.5 clk = ~clk;

  tlb_asid_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_page(lk_page), .lk_asid(lk_asid),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_hit(rsp_hit),
    .rsp_frame(rsp_frame), .rsp_prot(rsp_prot),
    .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_page(rf_page), .rf_asid(rf_asid),
    .rf_frame(rf_frame), .rf_prot(rf_prot),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en), .flush_asid(flush_asid),
    .hit_count(hit_count), .miss_count(miss_count)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int e_hits  = 0;
  int e_miss  = 0;
  bit done    = 1'b0;

  // reference table built from the requirements
  bit          mv  [16];
  logic [19:0] mp  [16];
  logic [7:0]  ma  [16];
  logic [19:0] mf  [16];
  logic [2:0]  mpr [16];
  int          mrot = 0;

  typedef struct {
    bit          hit;
    logic [19:0] fr;
    logic [2:0]  pr;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model_look(input logic [19:0] pg, input logic [7:0] as);
    exp_t e;
    e.hit = 1'b0; e.fr = '0; e.pr = '0; e.req = "";
    for (int i = 0; i < 16; i++)
      if (mv[i] && mp[i] == pg && ma[i] == as) begin
        e.hit = 1'b1; e.fr = mf[i]; e.pr = mpr[i];
      end
    return e;
  endfunction

  task automatic model_refill(input logic [19:0] pg, input logic [7:0] as,
                              input logic [19:0] fr, input logic [2:0] pr);
    int idx = -1;
    for (int i = 0; i < 16; i++)
      if (mv[i] && mp[i] == pg && ma[i] == as) idx = i;
    if (idx < 0)
      for (int i = 15; i >= 0; i--)
        if (!mv[i]) idx = i;
    if (idx < 0) begin
      idx = mrot;
      mrot = (mrot + 1) % 16;
    end
    mv[idx] = 1'b1; mp[idx] = pg; ma[idx] = as; mf[idx] = fr; mpr[idx] = pr;
  endtask

  // driver: one cycle starting at a falling edge
  task automatic cyc(input bit lk, input logic [19:0] pg, input logic [7:0] as,
                     input bit rf, input logic [19:0] rpg, input logic [7:0] ras,
                     input logic [19:0] rfr, input logic [2:0] rpr,
                     input bit fa, input bit fs, input logic [7:0] fas,
                     input string req);
    exp_t e;
    lk_valid = lk; lk_page = pg; lk_asid = as;
    rf_valid = rf; rf_page = rpg; rf_asid = ras; rf_frame = rfr; rf_prot = rpr;
    flush_all = fa; flush_asid_en = fs; flush_asid = fas;
    #1;
    if (lk && lk_ready) begin
      e = model_look(pg, as);
      e.req = req;
      if (e.hit) e_hits++; else e_miss++;
      sb_q.push_back(e);
    end
    if ((fa || fs) && rf)
      check(rf_ready == 1'b0, "R10", "rf_ready during flush", rf_ready, 0);
    if (rf && rf_ready) model_refill(rpg, ras, rfr, rpr);
    if (fa) begin
      for (int i = 0; i < 16; i++) mv[i] = 1'b0;
    end else if (fs) begin
      for (int i = 0; i < 16; i++) if (ma[i] == fas) mv[i] = 1'b0;
    end
    @(negedge clk);
    lk_valid = 1'b0; rf_valid = 1'b0; flush_all = 1'b0; flush_asid_en = 1'b0;
  endtask

  task automatic look(input logic [19:0] pg, input logic [7:0] as, input string req);
    cyc(1, pg, as, 0, '0, '0, '0, '0, 0, 0, '0, req);
  endtask

  task automatic fill(input logic [19:0] pg, input logic [7:0] as,
                      input logic [19:0] fr, input logic [2:0] pr);
    cyc(0, '0, '0, 1, pg, as, fr, pr, 0, 0, '0, "");
  endtask

  // monitor: pops the scoreboard on each response handshake
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R2", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          check({rsp_hit, rsp_frame, rsp_prot} == {e.hit, e.fr, e.pr}, e.req,
                "hit/frame/prot", {rsp_hit, rsp_frame, rsp_prot}, {e.hit, e.fr, e.pr});
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [19:0] held_fr;
    logic        held_hit;
    for (int i = 0; i < 16; i++) mv[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid", rsp_valid, 0);
    check(lk_ready == 1'b1 && rf_ready == 1'b1, "R1", "ready outputs",
          {lk_ready, rf_ready}, 2'b11);
    check(hit_count == 0 && miss_count == 0, "R1", "counters", hit_count + miss_count, 0);
    @(negedge clk);
    look(20'h00010, 8'd1, "R1");

    // R2: hits with frame and rights (bit0 R, bit1 W, bit2 X)
    fill(20'h00010, 8'd1, 20'hA0010, 3'b001);
    fill(20'h00011, 8'd1, 20'hA0011, 3'b011);
    fill(20'h00012, 8'd1, 20'hA0012, 3'b101);
    look(20'h00010, 8'd1, "R2");
    look(20'h00011, 8'd1, "R2");
    look(20'h00012, 8'd1, "R2");
    look(20'h00013, 8'd1, "R2");

    // R3: same page, different identifiers
    fill(20'h00055, 8'd3, 20'hB0001, 3'b111);
    fill(20'h00055, 8'd4, 20'hC0002, 3'b010);
    look(20'h00055, 8'd3, "R3");
    look(20'h00055, 8'd4, "R3");
    look(20'h00055, 8'd5, "R3");

    // R4: lookup sees contents before refill or flush of the same cycle
    cyc(1, 20'h00077, 8'd1, 1, 20'h00077, 8'd1, 20'hD0077, 3'b100, 0, 0, '0, "R4");
    look(20'h00077, 8'd1, "R4");
    cyc(1, 20'h00077, 8'd1, 0, '0, '0, '0, '0, 1, 0, '0, "R4");
    look(20'h00077, 8'd1, "R9");
    look(20'h00055, 8'd3, "R9");

    // R5/R6: fill every slot, then rotate
    for (int i = 0; i < 16; i++)
      fill(20'h00100 + 20'(i), (i < 8) ? 8'd1 : 8'd2, 20'h0A000 + 20'(i), 3'(i));
    fill(20'h00200, 8'd1, 20'h0B200, 3'b001);
    fill(20'h00201, 8'd1, 20'h0B201, 3'b010);
    look(20'h00100, 8'd1, "R6");
    look(20'h00101, 8'd1, "R6");
    look(20'h00102, 8'd1, "R6");
    look(20'h00200, 8'd1, "R6");
    look(20'h00201, 8'd1, "R6");
    // R7: rewrite in place, pointer stays on the third slot
    fill(20'h00102, 8'd1, 20'h0F0F0, 3'b110);
    look(20'h00102, 8'd1, "R7");
    fill(20'h00202, 8'd1, 20'h0B202, 3'b100);
    look(20'h00102, 8'd1, "R7");
    look(20'h00103, 8'd1, "R7");
    look(20'h00202, 8'd1, "R7");

    // R8: drop identifier 2 only
    cyc(0, '0, '0, 0, '0, '0, '0, '0, 0, 1, 8'd2, "R8");
    for (int i = 3; i < 16; i++)
      look(20'h00100 + 20'(i), (i < 8) ? 8'd1 : 8'd2, "R8");
    // R5: new pairs fill freed slots, no live entry lost
    fill(20'h00300, 8'd5, 20'h0C300, 3'b001);
    fill(20'h00301, 8'd5, 20'h0C301, 3'b001);
    fill(20'h00302, 8'd5, 20'h0C302, 3'b001);
    for (int i = 3; i < 8; i++) look(20'h00100 + 20'(i), 8'd1, "R5");
    look(20'h00200, 8'd1, "R5");
    look(20'h00302, 8'd5, "R5");

    // R10: refill offered during a flush is dropped
    cyc(0, '0, '0, 1, 20'h00400, 8'd6, 20'h0E400, 3'b001, 0, 1, 8'd9, "R10");
    look(20'h00400, 8'd6, "R10");
    cyc(0, '0, '0, 1, 20'h00401, 8'd6, 20'h0E401, 3'b001, 1, 0, '0, "R10");
    look(20'h00401, 8'd6, "R10");
    look(20'h00300, 8'd5, "R9");

    // R11: back-pressure
    fill(20'h00500, 8'd7, 20'h05555, 3'b011);
    rsp_ready = 1'b0;
    look(20'h00500, 8'd7, "R11");
    #1;
    check(rsp_valid == 1'b1 && lk_ready == 1'b0, "R11", "stall valid/ready",
          {rsp_valid, lk_ready}, 2'b10);
    held_fr = rsp_frame;
    held_hit = rsp_hit;
    lk_valid = 1'b1; lk_page = 20'h00010; lk_asid = 8'd1;
    repeat (2) @(negedge clk);
    #1;
    check(rsp_valid == 1'b1 && rsp_frame == held_fr && rsp_hit == held_hit, "R11",
          "held response", {rsp_valid, rsp_hit, rsp_frame}, {1'b1, held_hit, held_fr});
    lk_valid = 1'b0;
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R12: counters and drained scoreboard
    #1;
    check(sb_q.size() == 0, "R2", "responses outstanding", sb_q.size(), 0);
    check(hit_count == 32'(e_hits), "R12", "hit_count", hit_count, e_hits);
    check(miss_count == 32'(e_miss), "R12", "miss_count", miss_count, e_miss);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule